// File: doc/BRIEF.md
# Data Cache Maintenance Engine

This block is the maintenance sequencer that sits beside a small set-associative write-back data cache. Software reaches it through a narrow register port. Through that port it can enable or disable the cache, start a whole-cache write-back or a whole-cache invalidate, or act on a single line by address. The tag and dirty-state array is external to this block. The engine reads one set of that array at a time and sends per-way valid and dirty updates back to it. Dirty lines leave the cache through a simple valid/ready memory write port.

There is no separate flush-and-invalidate command. The invalidate commands follow a mode bit in the control register. When the mode bit is clear, dirty data is discarded. When it is set, each dirty line is written back before its valid bit is dropped. Per-line commands take the set index from the written address and, in split-tag mode, take the tag from a separate tag register that software loads beforehand. While an operation runs, the register port holds its ready signal low. The control register shows a write-back status bit for software to poll.

Register map, by `reg_addr`:

- 0: control register.
- 1: whole invalidate.
- 2: whole write-back.
- 3: line invalidate.
- 4: line write-back.
- 5: tag register.

Top module: `dcache_maint`

## Requirements
- R1: After reset `cache_en` is 0, `reg_ready` is 1, `mem_wr_valid` is 0 and a control-register read (address 0) returns 1 in bit 0.
- R2: In the control register, bit 0 set disables the cache (`cache_en` = ~bit0) and bit 1 is the invalidate write-back mode; both read back at the same positions.
- R3: A write of 1 to address 2 writes back every valid dirty line, with address {tag, set, zero offset}, in ascending set order and, within a set, ascending way order. Each written line becomes clean and stays valid. Clean lines and invalid lines are neither written nor changed.
- R4: A write of 1 to address 1 with mode bit 1 clear invalidates every line and issues no memory write.
- R5: A write of 1 to address 1 with mode bit 1 set writes back every valid dirty line in the R3 order and invalidates every line.
- R6: A write to address 1 or 2 with bit 0 clear starts nothing: `reg_ready` stays 1 and the array is unchanged.
- R7: A write to address 3 or 4 acts on exactly one line. The set index comes from address bits [7:4] at the default geometry and the offset bits [3:0] are ignored. Address 4 writes back the matching line if it is dirty, and leaves it valid and clean. Address 3 invalidates it, with a write-back first only when mode bit 1 is set.
- R8: In split-tag mode the line operations compare against the tag held at address 5, which reads back unchanged. The upper bits of the line address are not used for the compare.
- R9: A line operation whose tag matches no valid way of the indexed set changes nothing, writes nothing and is busy for exactly one cycle.
- R10: While an operation runs, `reg_ready` is 0 and further register writes wait. Control bit 2 reads 1 during any operation that may write back, and reads 0 during a discarding invalidate.
- R11: With `mem_wr_ready` held high, a whole-cache operation keeps the block busy for exactly SETS×WAYS cycles, which is 32 at the default geometry.
- R12: Once `mem_wr_valid` is raised, it and `mem_wr_addr` stay stable until `mem_wr_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write request |
| reg_addr | input | 3 | Register select for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Write accepted when high together with reg_wr_en |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| cache_en | output | 1 | Cache enable to the data path |
| arr_set | output | IDX_W | Set being examined in the tag array |
| arr_valid | input | WAYS | Valid bits of that set |
| arr_dirty | input | WAYS | Dirty bits of that set |
| arr_tag | input | WAYS*TAG_W | Tags of that set, way 0 in the low bits |
| upd_en | output | 1 | Write new state to one way of arr_set |
| upd_way | output | WAY_W | Way being updated |
| upd_valid | output | 1 | New valid bit |
| upd_dirty | output | 1 | New dirty bit |
| mem_wr_valid | output | 1 | Line write-back request |
| mem_wr_addr | output | ADDR_W | Line-aligned write-back address |
| mem_wr_ready | input | 1 | Memory accepts the write-back |

## Verification
The hardest situation to reach is a write-back that memory holds off, because it must occur in the middle of a whole-cache walk or of a flush-and-invalidate, with new register writes also pending. The bench fills its array model with a pattern that mixes valid, dirty and clean lines in every set. It then runs the walks once with memory always ready and once with a ready signal that stalls two cycles in three. A scoreboard queue holds the expected write-back addresses in walk order. During the stalled runs the bench checks that the request stays stable, and it tries a control write while the walk is running.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam logic [2:0] RA_CTRL       = 3'd0;
  localparam logic [2:0] RA_INV_ALL    = 3'd1;
  localparam logic [2:0] RA_WB_ALL     = 3'd2;
  localparam logic [2:0] RA_INV_LINE   = 3'd3;
  localparam logic [2:0] RA_WB_LINE    = 3'd4;
  localparam logic [2:0] RA_TAG        = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_LINE} eng_state_t;

  // capacity in bytes from the size configuration code
  function automatic int cache_bytes(input int size_code);
    return 512 << size_code;
  endfunction
endpackage

// File: rtl/dcm_regs.sv
module dcm_regs import dcm_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 24,
  parameter int OFF_W     = 4,
  parameter int IDX_W     = 4,
  parameter bit SPLIT_TAG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             wb_status,
  output logic             ctrl_dis,
  output logic             inv_wb_mode,
  output logic [31:0]      rdata,
  output logic             cmd_go,
  output logic             cmd_whole,
  output logic             cmd_flush,
  output logic [IDX_W-1:0] cmd_idx,
  output logic [TAG_W-1:0] cmd_tag
);
  logic [TAG_W-1:0] ptag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_dis    <= 1'b1;
      inv_wb_mode <= 1'b0;
      ptag_q      <= '0;
    end else if (wr_fire) begin
      if (addr == RA_CTRL) begin
        ctrl_dis    <= wdata[0];
        inv_wb_mode <= wdata[1];
      end
      if (addr == RA_TAG) ptag_q <= wdata[TAG_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == RA_CTRL) rdata[2:0] = {wb_status, inv_wb_mode, ctrl_dis};
    else if (addr == RA_TAG) rdata = 32'(ptag_q);
  end

  logic is_whole, is_line;
  assign is_whole  = (addr == RA_INV_ALL) || (addr == RA_WB_ALL);
  assign is_line   = (addr == RA_INV_LINE) || (addr == RA_WB_LINE);
  assign cmd_go    = wr_fire && ((is_whole && wdata[0]) || is_line);
  assign cmd_whole = is_whole;
  assign cmd_flush = (addr == RA_WB_ALL) || (addr == RA_WB_LINE);
  assign cmd_idx   = wdata[OFF_W +: IDX_W];

  generate
    if (SPLIT_TAG) begin : g_split
      assign cmd_tag = ptag_q;
    end else begin : g_joint
      assign cmd_tag = wdata[ADDR_W-1 -: TAG_W];
    end
  endgenerate
endmodule

// File: rtl/dcm_match.sv
module dcm_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 24,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      probe,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] eq;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign eq[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == probe);
    end
  endgenerate

  // lowest matching way wins
  always_comb begin
    hit     = |eq;
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--) if (eq[w]) hit_way = WAY_W'(w);
  end
endmodule

// File: rtl/dcm_engine.sv
module dcm_engine import dcm_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 2,
  parameter int SETS   = 16,
  parameter int TAG_W  = 24,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 4,
  parameter int WAY_W  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_go,
  input  logic                  cmd_whole,
  input  logic                  cmd_flush,
  input  logic [IDX_W-1:0]      cmd_idx,
  input  logic [TAG_W-1:0]      cmd_tag,
  input  logic                  inv_wb_mode,
  input  logic [WAYS-1:0]       arr_valid,
  input  logic [WAYS-1:0]       arr_dirty,
  input  logic [WAYS*TAG_W-1:0] arr_tag,
  input  logic                  mem_wr_ready,
  output logic [IDX_W-1:0]      arr_set,
  output logic                  upd_en,
  output logic [WAY_W-1:0]      upd_way,
  output logic                  upd_valid,
  output logic                  upd_dirty,
  output logic                  mem_wr_valid,
  output logic [ADDR_W-1:0]     mem_wr_addr,
  output logic                  busy,
  output logic                  wb_status,
  output logic                  op_flush,
  output logic                  op_wb,
  output logic                  line_miss
);
  eng_state_t       st_q;
  logic             op_flush_q, op_wb_q;
  logic [IDX_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;
  logic [TAG_W-1:0] tag_q;
  logic             hit;
  logic [WAY_W-1:0] hit_way;

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  dcm_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid(arr_valid), .tags(arr_tag), .probe(tag_q), .hit(hit), .hit_way(hit_way));

  logic             in_line, sel_v, sel_d, need_wb, step_done, last;
  logic [WAY_W-1:0] sel_way;
  logic [TAG_W-1:0] sel_t;

  always_comb begin
    in_line   = (st_q == S_LINE);
    busy      = (st_q != S_IDLE);
    sel_way   = in_line ? hit_way : way_q;
    sel_v     = in_line ? hit : arr_valid[way_q];
    sel_d     = arr_dirty[sel_way];
    sel_t     = arr_tag[sel_way*TAG_W +: TAG_W];
    need_wb   = busy && sel_v && sel_d && op_wb_q;
    step_done = busy && (!need_wb || mem_wr_ready);
    last      = (set_q == IDX_W'(SETS-1)) && (way_q == WAY_W'(WAYS-1));
  end

  assign arr_set      = set_q;
  assign mem_wr_valid = need_wb;
  assign mem_wr_addr  = line_base(sel_t, set_q);
  assign upd_en       = step_done && sel_v && (!op_flush_q || need_wb);
  assign upd_way      = sel_way;
  assign upd_valid    = op_flush_q;
  assign upd_dirty    = 1'b0;
  assign wb_status    = busy && op_wb_q;
  assign op_flush     = op_flush_q;
  assign op_wb        = op_wb_q;
  assign line_miss    = in_line && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      op_flush_q <= 1'b0;
      op_wb_q    <= 1'b0;
      set_q      <= '0;
      way_q      <= '0;
      tag_q      <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (cmd_go) begin
          op_flush_q <= cmd_flush;
          op_wb_q    <= cmd_flush || inv_wb_mode;
          way_q      <= '0;
          if (cmd_whole) begin
            st_q  <= S_WALK;
            set_q <= '0;
          end else begin
            st_q  <= S_LINE;
            set_q <= cmd_idx;
            tag_q <= cmd_tag;
          end
        end
        S_WALK: if (step_done) begin
          if (last) st_q <= S_IDLE;
          else if (way_q == WAY_W'(WAYS-1)) begin
            way_q <= '0;
            set_q <= set_q + 1'b1;
          end else way_q <= way_q + 1'b1;
        end
        S_LINE: if (step_done) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint import dcm_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int WAYS       = 2,
  parameter int SIZE_CODE  = 0,
  parameter bit SPLIT_TAG  = 1'b1,
  localparam int SETS  = cache_bytes(SIZE_CODE) / (LINE_BYTES * WAYS),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [2:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic                  reg_ready,
  output logic [31:0]           reg_rdata,
  output logic                  cache_en,
  output logic [IDX_W-1:0]      arr_set,
  input  logic [WAYS-1:0]       arr_valid,
  input  logic [WAYS-1:0]       arr_dirty,
  input  logic [WAYS*TAG_W-1:0] arr_tag,
  output logic                  upd_en,
  output logic [WAY_W-1:0]      upd_way,
  output logic                  upd_valid,
  output logic                  upd_dirty,
  output logic                  mem_wr_valid,
  output logic [ADDR_W-1:0]     mem_wr_addr,
  input  logic                  mem_wr_ready
);
  logic             eng_busy, eng_wb_status, eng_op_flush, eng_op_wb, eng_line_miss;
  logic             ctrl_dis, inv_wb_mode;
  logic             cmd_go, cmd_whole, cmd_flush;
  logic [IDX_W-1:0] cmd_idx;
  logic [TAG_W-1:0] cmd_tag;
  logic             wr_fire;

  assign reg_ready = !eng_busy;
  assign wr_fire   = reg_wr_en && reg_ready;
  assign cache_en  = !ctrl_dis;

  dcm_regs #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
             .SPLIT_TAG(SPLIT_TAG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr(reg_addr), .wdata(reg_wdata),
    .wb_status(eng_wb_status), .ctrl_dis(ctrl_dis), .inv_wb_mode(inv_wb_mode),
    .rdata(reg_rdata), .cmd_go(cmd_go), .cmd_whole(cmd_whole), .cmd_flush(cmd_flush),
    .cmd_idx(cmd_idx), .cmd_tag(cmd_tag));

  dcm_engine #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W),
               .IDX_W(IDX_W), .OFF_W(OFF_W), .WAY_W(WAY_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_whole(cmd_whole),
    .cmd_flush(cmd_flush), .cmd_idx(cmd_idx), .cmd_tag(cmd_tag),
    .inv_wb_mode(inv_wb_mode), .arr_valid(arr_valid), .arr_dirty(arr_dirty),
    .arr_tag(arr_tag), .mem_wr_ready(mem_wr_ready), .arr_set(arr_set),
    .upd_en(upd_en), .upd_way(upd_way), .upd_valid(upd_valid), .upd_dirty(upd_dirty),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .busy(eng_busy),
    .wb_status(eng_wb_status), .op_flush(eng_op_flush), .op_wb(eng_op_wb),
    .line_miss(eng_line_miss));
endmodule

// File: rtl/dcm_chk.sv
module dcm_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic              upd_en,
  input logic              upd_valid,
  input logic              upd_dirty,
  input logic              busy,
  input logic              op_flush,
  input logic              op_wb,
  input logic              line_miss
);
  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr));

  a_r3_flush_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && op_flush |-> upd_valid && !upd_dirty);

  a_r5_inv_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !op_flush |-> !upd_valid && !upd_dirty);

  a_r4_discard_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !op_wb |-> !mem_wr_valid);

  a_r9_miss_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    line_miss |=> !busy);

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !reg_ready);
endmodule

bind dcache_maint dcm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_ready(reg_ready), .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .upd_en(upd_en),
  .upd_valid(upd_valid), .upd_dirty(upd_dirty), .busy(eng_busy),
  .op_flush(eng_op_flush), .op_wb(eng_op_wb), .line_miss(eng_line_miss));

// File: tb/dcache_maint_tb.sv
module dcache_maint_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr_en = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        reg_ready, cache_en;
  logic [31:0] reg_rdata;
  logic [3:0]  arr_set;
  logic [1:0]  arr_valid, arr_dirty;
  logic [47:0] arr_tag;
  logic        upd_en, upd_valid, upd_dirty, mem_wr_valid;
  logic [0:0]  upd_way;
  logic [31:0] mem_wr_addr;
  logic        mem_wr_ready = 1;

  int checks = 0, fails = 0;
  bit stall_mode = 0;
  int rcnt = 0;

  logic        mv [16][2];
  logic        md [16][2];
  logic [23:0] mt [16][2];
  logic        snap_v [16][2];
  logic [31:0] exp_q [$];

  always #10 clk = ~clk;  // 50 MHz

  dcache_maint u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .cache_en(cache_en), .arr_set(arr_set), .arr_valid(arr_valid),
    .arr_dirty(arr_dirty), .arr_tag(arr_tag), .upd_en(upd_en), .upd_way(upd_way),
    .upd_valid(upd_valid), .upd_dirty(upd_dirty), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_ready(mem_wr_ready));

  // tag array model
  always_comb begin
    arr_valid = {mv[arr_set][1], mv[arr_set][0]};
    arr_dirty = {md[arr_set][1], md[arr_set][0]};
    arr_tag   = {mt[arr_set][1], mt[arr_set][0]};
  end

  logic       p_en, p_v, p_d, p_w;
  logic [3:0] p_s;
  always @(negedge clk) begin
    p_en = upd_en; p_s = arr_set; p_w = upd_way[0]; p_v = upd_valid; p_d = upd_dirty;
  end
  always @(posedge clk) if (p_en) begin
    mv[p_s][p_w] <= p_v;
    md[p_s][p_w] <= p_d;
  end

  always @(posedge clk) begin
    #2;
    rcnt++;
    mem_wr_ready = !stall_mode || (rcnt % 3 == 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  bit          held = 0;
  logic [31:0] held_addr;
  always @(negedge clk) if (rst_n) begin
    if (held) chk(mem_wr_valid && mem_wr_addr == held_addr, "R12", "request held",
                  mem_wr_addr, held_addr);
    held = mem_wr_valid && !mem_wr_ready;
    held_addr = mem_wr_addr;
    if (mem_wr_valid && mem_wr_ready) begin
      if (exp_q.size() == 0) chk(0, "R3/R5/R7", "unexpected write-back", mem_wr_addr, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(mem_wr_addr == e, "R3/R5/R7", "write-back address", mem_wr_addr, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    while (!reg_ready) @(negedge clk);
    @(posedge clk);
    #1 reg_wr_en = 0;
  endtask

  task automatic busy_cycles(output int n);
    n = 0;
    @(negedge clk);
    while (!reg_ready) begin n++; @(negedge clk); end
  endtask

  task automatic fill(input int seed);
    @(negedge clk);
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++) begin
      mv[s][w] <= ((s + w + seed) % 3) != 0;
      md[s][w] <= (((s ^ w ^ seed) & 1) == 1);
      mt[s][w] <= 24'hC00000 + 24'(s << 4) + 24'(w) + 24'(seed << 12);
    end
    @(negedge clk);
  endtask

  task automatic expect_walk();
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++)
      if (mv[s][w] && md[s][w]) exp_q.push_back({mt[s][w], 4'(s), 4'h0});
  endtask

  task automatic snapshot();
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++) snap_v[s][w] = mv[s][w];
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run hung", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n, bad;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++) begin
      mv[s][w] = 0; md[s][w] = 0; mt[s][w] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cache_en == 0, "R1", "cache_en", cache_en, 0);
    chk(reg_ready == 1, "R1", "reg_ready", reg_ready, 1);
    chk(mem_wr_valid == 0, "R1", "mem_wr_valid", mem_wr_valid, 0);
    reg_addr = 0; #1;
    chk(reg_rdata == 32'h1, "R1", "ctrl reset", reg_rdata, 1);
    rst_n = 1;

    // R2 control register
    wr(0, 32'h0);
    @(negedge clk);
    chk(cache_en == 1, "R2", "enable", cache_en, 1);
    wr(0, 32'h3);
    @(negedge clk); reg_addr = 0; #1;
    chk(cache_en == 0 && reg_rdata == 32'h3, "R2", "ctrl readback", reg_rdata, 3);
    wr(0, 32'h0);

    // R3 + R11 whole write-back, memory always ready
    fill(1); snapshot(); expect_walk();
    wr(2, 32'h1);
    busy_cycles(n);
    chk(n == 32, "R11", "whole op busy cycles", n, 32);
    @(negedge clk);
    bad = 0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++)
      if (mv[s][w] != snap_v[s][w] || (mv[s][w] && md[s][w])) bad++;
    chk(bad == 0 && exp_q.size() == 0, "R3", "lines clean and valid", bad, 0);

    // R6 command with bit0 clear
    fill(2); snapshot();
    wr(2, 32'h0);
    @(negedge clk);
    chk(reg_ready == 1, "R6", "write-back not started", reg_ready, 1);
    wr(1, 32'h2);
    @(negedge clk);
    bad = 0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++)
      if (mv[s][w] != snap_v[s][w]) bad++;
    chk(bad == 0 && reg_ready == 1, "R6", "invalidate not started", bad, 0);

    // R3 + R12 whole write-back with stalled memory, a control write waits (R10)
    stall_mode = 1; expect_walk();
    wr(2, 32'h1);
    @(negedge clk); reg_addr = 0; #1;
    chk(reg_rdata[2] == 1, "R10", "status during write-back", reg_rdata[2], 1);
    fork
      wr(0, 32'h1);
      begin @(negedge clk); chk(reg_ready == 0 && cache_en == 1, "R10",
                                "write stalled while busy", cache_en, 1); end
    join
    @(negedge clk);
    chk(cache_en == 0 && exp_q.size() == 0, "R10", "stalled write applied after",
        cache_en, 0);
    stall_mode = 0;
    wr(0, 32'h0);

    // R4 discarding invalidate
    fill(3);
    wr(1, 32'h1);
    @(negedge clk); reg_addr = 0; #1;
    chk(reg_rdata[2] == 0, "R10", "status during discard", reg_rdata[2], 0);
    busy_cycles(n);
    bad = 0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++) if (mv[s][w]) bad++;
    chk(bad == 0, "R4", "all invalid after discard", bad, 0);

    // R5 invalidate with write-back mode, stalled memory
    fill(4); expect_walk(); stall_mode = 1;
    wr(0, 32'h2);
    wr(1, 32'h1);
    busy_cycles(n);
    @(negedge clk);
    bad = 0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++) if (mv[s][w]) bad++;
    chk(bad == 0 && exp_q.size() == 0, "R5", "written back then invalid", bad, 0);
    stall_mode = 0;
    wr(0, 32'h0);

    // R7 + R8 line write-back using the tag register
    fill(5);
    @(negedge clk);
    mv[5][1] <= 1; md[5][1] <= 1; mt[5][1] <= 24'hABCDEF;
    mv[5][0] <= 1; md[5][0] <= 1; mt[5][0] <= 24'h111111;
    @(negedge clk);
    wr(5, 32'h00ABCDEF);
    @(negedge clk); reg_addr = 5; #1;
    chk(reg_rdata == 32'h00ABCDEF, "R8", "tag register readback", reg_rdata, 32'h00ABCDEF);
    exp_q.push_back({24'hABCDEF, 4'd5, 4'h0});
    wr(4, 32'h7700005C);   // set 5, offset C, upper bits unrelated
    busy_cycles(n);
    chk(mv[5][1] == 1 && md[5][1] == 0 && exp_q.size() == 0, "R7", "line cleaned",
        {mv[5][1], md[5][1]}, 2'b10);
    chk(md[5][0] == 1 && mv[5][0] == 1, "R7", "other way untouched", md[5][0], 1);

    // R7 line invalidate discarding
    @(negedge clk);
    mv[3][0] <= 1; md[3][0] <= 1; mt[3][0] <= 24'h123456;
    mv[3][1] <= 1; md[3][1] <= 1; mt[3][1] <= 24'h654321;
    @(negedge clk);
    wr(5, 32'h00123456);
    wr(3, 32'h00000039);
    busy_cycles(n);
    chk(mv[3][0] == 0 && mv[3][1] == 1, "R7", "line discarded", {mv[3][1], mv[3][0]}, 2'b10);

    // R7 line invalidate with write-back mode
    wr(0, 32'h2);
    wr(5, 32'h00654321);
    exp_q.push_back({24'h654321, 4'd3, 4'h0});
    wr(3, 32'hFFFFFF30);
    busy_cycles(n);
    chk(mv[3][1] == 0 && exp_q.size() == 0, "R7", "line written back and dropped",
        mv[3][1], 0);
    wr(0, 32'h0);

    // R9 miss
    snapshot();
    wr(5, 32'h00DEAD00);
    wr(4, 32'h00000050);
    busy_cycles(n);
    chk(n == 1, "R9", "miss busy cycles", n, 1);
    bad = 0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++)
      if (mv[s][w] != snap_v[s][w]) bad++;
    chk(bad == 0 && md[5][0] == 1, "R9", "miss changes nothing", bad, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule